// File: doc/BRIEF.md
# Character LCD Refresh Sequencer

This block drives a 16-column, 2-row character display over its 8-bit parallel bus, clocked by a slow 20 kHz clock (50 µs per cycle). After reset it sends a fixed set of configuration commands. These commands select 8-bit, two-line operation, turn the display on, clear it, and make the cursor advance by one after each character. The block then stays idle until an update flag arrives.

The update flag comes with an 8-bit parameter number and an 8-bit parameter value. When the flag is seen, the block stores both values. It then redraws the screen. Row one shows `P:` followed by the number in two hexadecimal digits. Row two shows `V:` followed by the value in the same form.

The block is built as two machines:
- A control machine picks each byte and its register-select level, then offers it with a one-cycle `ready` pulse.
- A write machine places the byte on the bus, pulses enable, waits out a fixed settling delay, and answers with a one-cycle `done` pulse.

The block never reads the display's busy flag; fixed delays take its place.

Top module: `charlcd_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `lcd_en` is 0. `lcd_rw` is 0 at every cycle, because the block only ever writes.
- R2: After reset, the first four bytes written all have `lcd_rs`=0, in this order: 0x38, 0x0C, 0x01, 0x06. After these, no enable pulse occurs until `upd_flag` has been seen high.
- R3: A refresh writes exactly ten bytes in this order:
  - command 0x80 (rs=0), then the characters 0x50 ('P') and 0x3A (':') (rs=1);
  - the high and low nibble of the number as ASCII hex (rs=1);
  - command 0xC0 (rs=0), then the characters 0x56 ('V') and 0x3A (':') (rs=1);
  - the high and low nibble of the value as ASCII hex (rs=1).
- R4: A nibble from 0 to 9 is written as 0x30 plus the nibble. A nibble from 10 to 15 is written as 0x41 plus (nibble − 10), which gives uppercase letters.
- R5: `lcd_en` stays high for exactly one cycle. `lcd_data` and `lcd_rs` stay unchanged from the cycle before `lcd_en` rises through the cycle it is high.
- R6: After each byte, `lcd_en` stays low for at least `POST_CYC` cycles (default 2). After the clear command 0x01, it stays low for at least `CLR_CYC` cycles (default 40).
- R7: A refresh shows the number and value that were on the inputs in the cycle `upd_flag` was high. Changes on `param_num` and `param_val` without a flag do not change a refresh that is running, and they start no refresh.
- R8: Any number of flags that arrive during a refresh (or during initialisation) lead to exactly one further refresh. That refresh shows the data from the last of those flags, and after it the block goes idle.
- R9: The control machine offers a byte (`ready`) only while the write machine is idle. Each `done` pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sequencer clock (20 kHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_flag | input | 1 | One-cycle flag: a new number and value are present |
| param_num | input | 8 | Parameter number shown on row one |
| param_val | input | 8 | Parameter value shown on row two |
| lcd_rs | output | 1 | Register select: 0 for command, 1 for character |
| lcd_rw | output | 1 | Read/write select, always 0 (write) |
| lcd_en | output | 1 | Enable strobe; the display latches the bus on its falling edge |
| lcd_data | output | 8 | Parallel data bus |

## Verification
A step counter that skips or repeats a position shows up at once in the order of the captured bytes. The bench notices it when it compares that refresh, at the latest ten bytes later.

A write machine that leaves its delay state too early shows as an enable gap that is too short. This is seen at the very next rising edge of enable. It is most visible after the clear command, where the gap must be at least forty cycles.

A lost or duplicated pending flag changes the number of refreshes. The bench detects this only after an idle window in which any extra enable pulse counts as an error.

A data register that is not frozen during a refresh shows as the wrong hex digits in that same refresh.

// File: rtl/charlcd_pkg.sv
// Package: shared state types and byte-generation helpers for the
// character LCD sequencer. Assumes an 8-bit bus and ASCII characters.
package charlcd_pkg;

    typedef enum logic [1:0] {
        C_INIT,
        C_IDLE,
        C_SHOW
    } ctrl_state_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SETUP,
        W_PULSE,
        W_POST
    } wr_state_t;

    localparam int INIT_LEN = 4;
    localparam int SHOW_LEN = 10;

    // Uppercase ASCII hex character for one nibble.
    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        if (nib < 4'd10) begin
            return 8'h30 + {4'h0, nib};
        end
        return 8'h37 + {4'h0, nib};
    endfunction

    // Configuration byte for a given step; every byte is a command (rs=0).
    function automatic logic [8:0] init_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return {1'b0, 8'h38};
            4'd1:    return {1'b0, 8'h0C};
            4'd2:    return {1'b0, 8'h01};
            default: return {1'b0, 8'h06};
        endcase
    endfunction

    // Refresh byte for a given step: {rs, data}.
    function automatic logic [8:0] show_byte(input logic [3:0] idx,
                                             input logic [7:0] num,
                                             input logic [7:0] val);
        case (idx)
            4'd0:    return {1'b0, 8'h80};
            4'd1:    return {1'b1, 8'h50};
            4'd2:    return {1'b1, 8'h3A};
            4'd3:    return {1'b1, hex_char(num[7:4])};
            4'd4:    return {1'b1, hex_char(num[3:0])};
            4'd5:    return {1'b0, 8'hC0};
            4'd6:    return {1'b1, 8'h56};
            4'd7:    return {1'b1, 8'h3A};
            4'd8:    return {1'b1, hex_char(val[7:4])};
            default: return {1'b1, hex_char(val[3:0])};
        endcase
    endfunction

endpackage

// File: rtl/charlcd_ctrl.sv
// Control machine. Steps through the configuration bytes after reset.
// Then, for each refresh, it steps through the ten display bytes.
// Each byte is offered with a one-cycle ready pulse, and the machine
// waits for the writer's done pulse before offering the next one.
// Assumes upd_flag is a one-cycle pulse in this clock domain.
module charlcd_ctrl
    import charlcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_flag,
    input  logic [7:0] param_num,
    input  logic [7:0] param_val,
    input  logic       byte_done,
    output logic       byte_ready,
    output logic       byte_rs,
    output logic [7:0] byte_data
);

    ctrl_state_t state;
    logic [3:0]  step;
    logic        waiting;
    logic        pending;
    logic [7:0]  shadow_num, shadow_val;
    logic [7:0]  disp_num, disp_val;
    logic [8:0]  cur_byte;

    // Pick the byte for the current step.
    always_comb begin
        if (state == C_INIT) begin
            cur_byte = init_byte(step);
        end else begin
            cur_byte = show_byte(step, disp_num, disp_val);
        end
    end

    // Store the inputs whenever the flag is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_num <= '0;
            shadow_val <= '0;
        end else if (upd_flag) begin
            shadow_num <= param_num;
            shadow_val <= param_val;
        end
    end

    // Sequence the steps, run the ready/done handshake and hold a pending refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= C_INIT;
            step       <= '0;
            waiting    <= 1'b0;
            pending    <= 1'b0;
            disp_num   <= '0;
            disp_val   <= '0;
            byte_ready <= 1'b0;
            byte_rs    <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_ready <= 1'b0;
            if (upd_flag && state != C_IDLE) begin
                pending <= 1'b1;
            end
            case (state)
                C_IDLE: begin
                    if (upd_flag) begin
                        disp_num <= param_num;
                        disp_val <= param_val;
                        state    <= C_SHOW;
                        step     <= '0;
                    end else if (pending) begin
                        disp_num <= shadow_num;
                        disp_val <= shadow_val;
                        pending  <= 1'b0;
                        state    <= C_SHOW;
                        step     <= '0;
                    end
                end
                default: begin
                    if (!waiting) begin
                        byte_ready <= 1'b1;
                        byte_rs    <= cur_byte[8];
                        byte_data  <= cur_byte[7:0];
                        waiting    <= 1'b1;
                    end else if (byte_done) begin
                        waiting <= 1'b0;
                        if ((state == C_INIT && step == 4'(INIT_LEN - 1)) ||
                            (state == C_SHOW && step == 4'(SHOW_LEN - 1))) begin
                            state <= C_IDLE;
                            step  <= '0;
                        end else begin
                            step <= step + 4'd1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/charlcd_writer.sv
// Write machine. Accepts one byte per ready pulse and follows these steps:
//   1. put the byte on the bus for one setup cycle;
//   2. hold enable high for one cycle;
//   3. wait out the settling delay;
//   4. pulse done for one cycle.
// The clear command gets the long delay; every other byte gets the short one.
// Assumes ready is offered only while the machine is idle.
module charlcd_writer
    import charlcd_pkg::*;
#(
    parameter int POST_CYC = 2,
    parameter int CLR_CYC  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_ready,
    input  logic       in_rs,
    input  logic [7:0] in_data,
    output logic       out_done,
    output logic       out_idle,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_data
);

    localparam int CNT_W = $clog2(CLR_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(POST_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(CLR_CYC - 1);

    wr_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic             is_clear;

    assign is_clear = !lcd_rs && (lcd_data == 8'h01);
    assign lcd_en   = (state == W_PULSE);
    assign out_idle = (state == W_IDLE);
    assign lcd_rw   = 1'b0;

    // Move through setup, pulse and settling, then signal done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            cnt      <= '0;
            out_done <= 1'b0;
            lcd_rs   <= 1'b0;
            lcd_data <= '0;
        end else begin
            out_done <= 1'b0;
            case (state)
                W_IDLE: begin
                    if (in_ready) begin
                        lcd_rs   <= in_rs;
                        lcd_data <= in_data;
                        state    <= W_SETUP;
                    end
                end
                W_SETUP: state <= W_PULSE;
                W_PULSE: begin
                    cnt   <= is_clear ? LONG_LD : SHORT_LD;
                    state <= W_POST;
                end
                default: begin
                    if (cnt == '0) begin
                        out_done <= 1'b1;
                        state    <= W_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/charlcd_sequencer.sv
// Top level: joins the control machine and the write machine through
// the ready/done byte handshake. Runs from the slow display clock.
module charlcd_sequencer #(
    parameter int POST_CYC = 2,
    parameter int CLR_CYC  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_flag,
    input  logic [7:0] param_num,
    input  logic [7:0] param_val,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_data
);

    logic       byte_ready;
    logic       byte_rs;
    logic [7:0] byte_data;
    logic       byte_done;
    logic       wr_idle;

    charlcd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_flag   (upd_flag),
        .param_num  (param_num),
        .param_val  (param_val),
        .byte_done  (byte_done),
        .byte_ready (byte_ready),
        .byte_rs    (byte_rs),
        .byte_data  (byte_data)
    );

    charlcd_writer #(
        .POST_CYC (POST_CYC),
        .CLR_CYC  (CLR_CYC)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ready (byte_ready),
        .in_rs    (byte_rs),
        .in_data  (byte_data),
        .out_done (byte_done),
        .out_idle (wr_idle),
        .lcd_rs   (lcd_rs),
        .lcd_rw   (lcd_rw),
        .lcd_en   (lcd_en),
        .lcd_data (lcd_data)
    );

endmodule

// File: rtl/charlcd_sequencer_chk.sv
// Checker: timing properties of the display bus and the internal handshake.
// It is attached to every instance of the top module by the bind below.
module charlcd_sequencer_chk #(
    parameter int CLR_CYC  = 40,
    parameter int POST_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lcd_en,
    input logic       lcd_rs,
    input logic [7:0] lcd_data,
    input logic       byte_ready,
    input logic       byte_done,
    input logic       wr_idle
);

    localparam int GW = $clog2(CLR_CYC + 2);

    logic [GW-1:0] gap_cnt;
    logic          last_clr;
    logic          seen_pulse;

    // Count the low cycles of enable since the last pulse, and note whether that pulse wrote the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt    <= '0;
            last_clr   <= 1'b0;
            seen_pulse <= 1'b0;
        end else if (lcd_en) begin
            gap_cnt    <= '0;
            last_clr   <= !lcd_rs && (lcd_data == 8'h01);
            seen_pulse <= 1'b1;
        end else if (gap_cnt != GW'(CLR_CYC + 1)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_en_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |=> !lcd_en);

    assert_bus_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    assert_clear_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && seen_pulse && last_clr) |-> (gap_cnt >= GW'(CLR_CYC)));

    assert_post_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && seen_pulse) |-> (gap_cnt >= GW'(POST_CYC)));

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> wr_idle);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

endmodule

bind charlcd_sequencer charlcd_sequencer_chk #(
    .CLR_CYC  (CLR_CYC),
    .POST_CYC (POST_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_en     (lcd_en),
    .lcd_rs     (lcd_rs),
    .lcd_data   (lcd_data),
    .byte_ready (byte_ready),
    .byte_done  (byte_done),
    .wr_idle    (wr_idle)
);

// File: tb/charlcd_sequencer_tb.sv
// Bench: a monitor records each enable pulse and the gaps between them.
// A vector table then drives refreshes, and directed tests cover reset,
// initialisation, freezing of the inputs and coalescing of flags.
module charlcd_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_flag = 1'b0;
    logic [7:0] param_num = 8'h00;
    logic [7:0] param_val = 8'h00;
    logic       lcd_rs, lcd_rw, lcd_en;
    logic [7:0] lcd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    charlcd_sequencer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_flag  (upd_flag),
        .param_num (param_num),
        .param_val (param_val),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_en    (lcd_en),
        .lcd_data  (lcd_data)
    );

    // Monitor storage: captured bytes plus timing violations.
    logic [8:0] cap [0:255];
    int  ncap = 0;
    int  low_run = 0;
    logic prev_en = 1'b0;
    logic prev_clr = 1'b0;
    int  width_err = 0;
    int  gap_err = 0;
    int  clr_gap_min = 1000;
    int  rw_err = 0;

    // Sample away from the active edge: record each pulse and check widths and gaps.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_en <= 1'b0;
            low_run <= 0;
        end else begin
            if (lcd_rw !== 1'b0) rw_err <= rw_err + 1;
            if (lcd_en && !prev_en) begin
                if (ncap > 0) begin
                    if (low_run < 2) gap_err <= gap_err + 1;
                    if (prev_clr && low_run < clr_gap_min) clr_gap_min <= low_run;
                end
                if (ncap < 256) cap[ncap] <= {lcd_rs, lcd_data};
                ncap     <= ncap + 1;
                prev_clr <= (!lcd_rs && lcd_data == 8'h01);
            end
            if (lcd_en && prev_en) width_err <= width_err + 1;
            low_run <= lcd_en ? 0 : low_run + 1;
            prev_en <= lcd_en;
        end
    end

    task automatic check(input string req, input logic ok,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hex(input logic [3:0] n);
        return (n < 10) ? (8'h30 + 8'(n)) : (8'h41 + 8'(n) - 8'd10);
    endfunction

    function automatic logic [8:0] exp_byte(input int k, input logic [7:0] p,
                                            input logic [7:0] v);
        logic [8:0] r;
        case (k)
            0: r = {1'b0, 8'h80};
            1: r = {1'b1, 8'h50};
            2: r = {1'b1, 8'h3A};
            3: r = {1'b1, exp_hex(p[7:4])};
            4: r = {1'b1, exp_hex(p[3:0])};
            5: r = {1'b0, 8'hC0};
            6: r = {1'b1, 8'h56};
            7: r = {1'b1, 8'h3A};
            8: r = {1'b1, exp_hex(v[7:4])};
            default: r = {1'b1, exp_hex(v[3:0])};
        endcase
        return r;
    endfunction

    task automatic wait_bytes(input int target);
        for (int i = 0; i < 3000 && ncap < target; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_flag(input logic [7:0] p, input logic [7:0] v);
        @(negedge clk);
        param_num = p;
        param_val = v;
        upd_flag  = 1'b1;
        @(negedge clk);
        upd_flag  = 1'b0;
    endtask

    task automatic check_refresh(input string req, input int base,
                                 input logic [7:0] p, input logic [7:0] v);
        for (int k = 0; k < 10; k++) begin
            check(req, cap[base + k] == exp_byte(k, p, v),
                  32'(cap[base + k]), 32'(exp_byte(k, p, v)));
        end
    endtask

    // Vector table: {number, value}. It includes all-digit, all-letter and mixed nibbles.
    localparam logic [15:0] VEC [0:5] = '{16'h0000, 16'hFFFF, 16'h9A09,
                                         16'h3CA5, 16'h7E81, 16'hB60F};

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: enable low while reset is held
        check("R1", lcd_en == 1'b0, 32'(lcd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", lcd_en == 1'b0 && lcd_rw == 1'b0, 32'({lcd_en, lcd_rw}), 0);

        // R2: configuration sequence, then nothing without a flag
        wait_bytes(4);
        check("R2", cap[0] == 9'h038, 32'(cap[0]), 32'h038);
        check("R2", cap[1] == 9'h00C, 32'(cap[1]), 32'h00C);
        check("R2", cap[2] == 9'h001, 32'(cap[2]), 32'h001);
        check("R2", cap[3] == 9'h006, 32'(cap[3]), 32'h006);
        param_num = 8'h55;
        param_val = 8'hAA;
        repeat (200) @(negedge clk);
        check("R2", ncap == 4, 32'(ncap), 4);
        check("R6", clr_gap_min >= 40, 32'(clr_gap_min), 40);

        // R3 and R4: walk the vector table
        for (int i = 0; i < 6; i++) begin
            base = ncap;
            pulse_flag(VEC[i][15:8], VEC[i][7:0]);
            wait_bytes(base + 10);
            check_refresh("R3_R4", base, VEC[i][15:8], VEC[i][7:0]);
        end

        // R7: inputs change during a refresh without a flag
        base = ncap;
        pulse_flag(8'h12, 8'h34);
        param_num = 8'hEE;
        param_val = 8'hDD;
        wait_bytes(base + 10);
        check_refresh("R7", base, 8'h12, 8'h34);
        repeat (200) @(negedge clk);
        check("R7", ncap == base + 10, 32'(ncap), 32'(base + 10));

        // R8: two flags during a refresh lead to one more refresh with the last data
        base = ncap;
        pulse_flag(8'h01, 8'h02);
        repeat (5) @(negedge clk);
        pulse_flag(8'hA1, 8'hB2);
        repeat (3) @(negedge clk);
        pulse_flag(8'hC3, 8'hD4);
        wait_bytes(base + 20);
        check_refresh("R8", base, 8'h01, 8'h02);
        check_refresh("R8", base + 10, 8'hC3, 8'hD4);
        repeat (300) @(negedge clk);
        check("R8", ncap == base + 20, 32'(ncap), 32'(base + 20));

        // R5, R6, R1: timing accumulated by the monitor over the whole run
        check("R5", width_err == 0, 32'(width_err), 0);
        check("R6", gap_err == 0, 32'(gap_err), 0);
        check("R1", rw_err == 0, 32'(rw_err), 0);

        // R1: a reset in the middle of a refresh restarts the configuration sequence
        pulse_flag(8'h44, 8'h44);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", lcd_en == 1'b0, 32'(lcd_en), 0);
        base = ncap;
        rst_n = 1'b1;
        wait_bytes(base + 4);
        check("R2", cap[base] == 9'h038, 32'(cap[base]), 32'h038);
        check("R2", cap[base + 3] == 9'h006, 32'(cap[base + 3]), 32'h006);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule